// File: doc/BRIEF.md
# Indirect Bus Access Bridge

The bridge lets a host that only has a 64-bit register port perform single transfers on a 32-bit internal request/response bus. The host sees four registers, chosen by two address bits: a command register, an inert reset register, a completion/result register and a write-data register. Writing a command word starts one internal read or write at once. While that transfer is outstanding, the bridge ignores any further command.

When the transfer ends, the bridge packs a done flag and, for reads, the returned word into one result word. The host reads that word, and the read clears it. A read that the bus answers with an error still completes, and it reports all ones as its data. A write always completes with only the done flag set.

The internal side holds a valid strobe together with address, size, direction and write data until the slave answers with a one-cycle ready pulse. The read data and the error flag arrive on that same pulse.

Top module: `ind_bus_bridge`

## Requirements
- R1: Host address bits [4:3] select the register: 0 command, 1 reset, 2 result, 3 write data. Reads of the command and reset registers return zero. Host writes to the reset and result registers change nothing.
- R2: A command write while idle raises `bus_valid` on the next cycle. Command bit 48 set gives a read (`bus_we`=0) and clear gives a write. Command bits [59:56] appear on `bus_size` and bits [31:0] appear on `bus_addr`.
- R3: A host write to the data register stores write bits [63:32]. A host read of the data register returns the stored value in [63:32], with [31:0] zero.
- R4: For a write command, `bus_wdata` carries the stored data word with its first byte in [31:24] and its last byte in [7:0].
- R5: `bus_valid` stays high until the cycle `bus_ready` is seen. During that time address, size, direction and write data do not change.
- R6: A read that completes without error sets the result word to bit 11 set, with `bus_rdata` placed at [57:26] and all other bits zero.
- R7: A read that completes with `bus_err` set sets the result word to bit 11 set, with [57:26] all ones and all other bits zero.
- R8: A write that completes sets the result word to bit 11 only, whatever the value of `bus_err`.
- R9: A host read of the result register returns its contents in the same cycle and leaves it zero afterwards. A completion arriving in that same cycle takes priority over the clear.
- R10: While `bus_valid` is high, the result register reads zero and command writes are ignored. No second transfer starts and the outstanding transfer does not change.
- R11: After reset `bus_valid` is low and every readable register returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = host write, 0 = host read |
| host_addr | input | 2 | Register select (host address bits [4:3]) |
| host_wdata | input | 64 | Host write value |
| host_rdata | output | 64 | Host read value, valid in the access cycle |
| bus_valid | output | 1 | Internal request outstanding |
| bus_we | output | 1 | Internal request is a write |
| bus_addr | output | 32 | Internal address |
| bus_size | output | 4 | Transfer size in bytes |
| bus_wdata | output | 32 | Internal write data, first byte in [31:24] |
| bus_ready | input | 1 | Slave completion pulse |
| bus_rdata | input | 32 | Slave read data, valid with `bus_ready` |
| bus_err | input | 1 | Slave error, valid with `bus_ready` |

## Verification
Host read data is combinational, so the bench samples `host_rdata` within the access cycle, just after driving the inputs on a falling edge. Request fields appear one rising edge after the command write, and the bench checks them on the following falling edge. The result word is loaded on the edge where `bus_ready` meets `bus_valid`, which is the same edge on which `bus_valid` falls. The bench therefore waits until `bus_valid` reads low on a falling edge and only then reads the result register. The slave model's ready latency is swept from zero to three cycles, so each of these timings is exercised with several gaps.

// File: rtl/ind_bus_bridge.sv
module ind_bus_bridge #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int SW = 4,
  parameter int RD_BIT = 48,
  parameter int SZ_LSB = 56,
  parameter int DONE_BIT = 11,
  parameter int RDAT_LSB = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic          host_we,
  input  logic [4:3]    host_addr,
  input  logic [63:0]   host_wdata,
  output logic [63:0]   host_rdata,
  output logic          bus_valid,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [SW-1:0] bus_size,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ready,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_err
);
  localparam logic [1:0] SEL_CMD = 2'd0, SEL_RST = 2'd1, SEL_RES = 2'd2, SEL_DAT = 2'd3;

  logic [DW-1:0] data_q;
  logic [63:0]   res_q;

  wire wr     = host_req && host_we;
  wire rd     = host_req && !host_we;
  wire launch = wr && host_addr == SEL_CMD && !bus_valid;
  wire finish = bus_valid && bus_ready;

  logic [63:0] done_word;
  always_comb begin
    done_word = 64'd0;
    done_word[DONE_BIT] = 1'b1;
    if (!bus_we)
      done_word[RDAT_LSB +: DW] = bus_err ? {DW{1'b1}} : bus_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_valid <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_size  <= '0;
      bus_wdata <= '0;
      data_q    <= '0;
      res_q     <= '0;
    end else begin
      if (wr && host_addr == SEL_DAT)
        data_q <= host_wdata[63:32];
      if (launch) begin
        bus_valid <= 1'b1;
        bus_we    <= !host_wdata[RD_BIT];
        bus_size  <= host_wdata[SZ_LSB +: SW];
        bus_addr  <= host_wdata[AW-1:0];
        bus_wdata <= data_q;
        res_q     <= '0;
      end else if (finish) begin
        bus_valid <= 1'b0;
        res_q     <= done_word;
      end else if (rd && host_addr == SEL_RES) begin
        res_q <= '0;
      end
    end
  end

  always_comb begin
    case (host_addr)
      SEL_RES: host_rdata = res_q;
      SEL_DAT: host_rdata = {data_q, 32'd0};
      default: host_rdata = 64'd0;
    endcase
  end

  a_r5_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_size)
                                 && $stable(bus_we) && $stable(bus_wdata));

  a_r10_busy_result_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && rd && host_addr == SEL_RES |-> host_rdata == 64'd0);

  a_r1_ctl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd && (host_addr == SEL_CMD || host_addr == SEL_RST) |-> host_rdata == 64'd0);

  a_r8_write_done_only: assert property (@(posedge clk) disable iff (!rst_n)
    finish && bus_we |=> res_q == (64'd1 << DONE_BIT));

  a_r7_err_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    finish && !bus_we && bus_err |=> res_q[RDAT_LSB +: DW] == {DW{1'b1}} && res_q[DONE_BIT]);

  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd && host_addr == SEL_RES && !finish |=> res_q == 64'd0);

  a_r2_launch_valid: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> bus_valid);
endmodule

// File: tb/ind_bus_bridge_test.sv
`timescale 1ns/1ps
module ind_bus_bridge_test;
  logic clk = 0;
  logic rst_n = 0;
  logic host_req = 0, host_we = 0;
  logic [4:3] host_addr = 0;
  logic [63:0] host_wdata = 0;
  logic [63:0] host_rdata;
  logic bus_valid, bus_we;
  logic [31:0] bus_addr, bus_wdata;
  logic [3:0] bus_size;
  logic bus_ready = 0;
  logic [31:0] bus_rdata = 0;
  logic bus_err = 0;

  int total = 0, bad = 0;
  int dly = 0, cnt = 0;
  int ops = 0;

  always #2 clk = ~clk;

  ind_bus_bridge uut (.*);

  function automatic logic [31:0] rd_val(logic [31:0] a);
    return {a[7:0], a[15:8], a[23:16], a[31:24]} ^ 32'h5A5A_1234;
  endfunction
  function automatic logic slv_err(logic [31:0] a);
    return a[31:28] == 4'hE;
  endfunction

  always @(posedge clk) begin
    if (bus_ready) begin
      bus_ready <= 0; cnt <= 0; bus_err <= 0;
    end else if (bus_valid) begin
      if (cnt >= dly) begin
        bus_ready <= 1;
        bus_rdata <= rd_val(bus_addr);
        bus_err   <= slv_err(bus_addr);
        ops <= ops + 1;
      end else cnt <= cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [1:0] s, input logic [63:0] d);
    @(negedge clk);
    host_req = 1; host_we = 1; host_addr = s; host_wdata = d;
    @(negedge clk);
    host_req = 0; host_we = 0;
  endtask

  task automatic hr(input logic [1:0] s, output logic [63:0] d);
    @(negedge clk);
    host_req = 1; host_we = 0; host_addr = s;
    #0.5 d = host_rdata;
    @(negedge clk);
    host_req = 0;
  endtask

  task automatic wait_idle();
    while (bus_valid) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] v;
    logic [63:0] exp;
    logic [31:0] a, dw;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R11 valid low after reset", {63'd0, bus_valid}, 64'd0);
    for (int s = 0; s < 4; s++) begin
      hr(s[1:0], v);
      chk("R11 register zero after reset", v, 64'd0);
    end

    hw(2'd3, 64'hDEAD_BEEF_1111_2222);
    hr(2'd3, v);
    chk("R3 data readback", v, 64'hDEAD_BEEF_0000_0000);
    hw(2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    hw(2'd2, 64'hFFFF_FFFF_FFFF_FFFF);
    hr(2'd3, v);
    chk("R1 reset/result write no effect on data", v, 64'hDEAD_BEEF_0000_0000);
    hr(2'd2, v);
    chk("R1 result write no effect", v, 64'd0);
    chk("R1 no bus op from reset write", {63'd0, bus_valid}, 64'd0);

    for (int sz = 0; sz < 16; sz++)
      for (int dir = 0; dir < 2; dir++)
        for (int e = 0; e < 2; e++) begin
          dly = sz % 4;
          a = {(e != 0) ? 4'hE : 4'h1, 4'(sz), 8'(sz * 17 + dir), 16'hC0DE ^ 16'(sz << 4)};
          dw = 32'h0102_0304 * (sz + 1) ^ 32'(dir << 9);
          hw(2'd3, {dw, 32'h0});
          hw(2'd0, {4'h0, 4'(sz), 7'd0, (dir == 1), 16'd0, a});
          chk("R2 valid raised", {63'd0, bus_valid}, 64'd1);
          chk("R2 address", {32'd0, bus_addr}, {32'd0, a});
          chk("R2 size", {60'd0, bus_size}, {60'd0, 4'(sz)});
          chk("R2 direction", {63'd0, bus_we}, {63'd0, dir == 0});
          if (dir == 0) chk("R4 write data", {32'd0, bus_wdata}, {32'd0, dw});
          wait_idle();
          hr(2'd1, v);
          chk("R1 reset reg reads zero", v, 64'd0);
          hr(2'd0, v);
          chk("R1 command reg reads zero", v, 64'd0);
          hw(2'd2, 64'hFFFF_FFFF_FFFF_FFFF);
          exp = 64'd1 << 11;
          if (dir == 1) exp = exp | ({32'd0, (e != 0) ? 32'hFFFF_FFFF : rd_val(a)} << 26);
          hr(2'd2, v);
          if (dir == 0) chk("R8 write result", v, exp);
          else if (e != 0) chk("R7 failed read result", v, exp);
          else chk("R6 read result", v, exp);
          hr(2'd2, v);
          chk("R9 result cleared after read", v, 64'd0);
        end

    dly = 3;
    a = 32'h2000_0040;
    hw(2'd0, {8'h04, 7'd0, 1'b1, 16'd0, a});
    v = ops;
    hr(2'd2, v);
    chk("R10 result zero while busy", v, 64'd0);
    hw(2'd0, {8'h01, 7'd0, 1'b0, 16'd0, 32'h3000_0000});
    chk("R10 busy command ignored addr", {32'd0, bus_addr}, {32'd0, a});
    chk("R5 valid held", {63'd0, bus_valid}, 64'd1);
    chk("R10 busy command ignored dir", {63'd0, bus_we}, 64'd0);
    wait_idle();
    repeat (6) @(negedge clk);
    chk("R10 no second transfer", {63'd0, bus_valid}, 64'd0);
    hr(2'd2, v);
    chk("R6 read result after ignored cmd", v, (64'd1 << 11) | ({32'd0, rd_val(a)} << 26));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule